// File: doc/BRIEF.md
# T1/E1 Transmit Error Injector

This block sits in the transmit bit path of a T1/E1 framer, just before line coding. Each incoming bit carries a class tag and a start-of-frame flag. The tag says whether the bit is a frame-alignment bit, a multiframe bit, a CRC bit, a test-pattern generator bit or payload. The start-of-frame flag marks the first bit position of each frame. In T1 that position is the F-bit; in E1 it is bit 1 of timeslot 0. The tags already carry the framing mode, so the block needs no separate T1/E1 select.

Software writes a one-shot inject register to request test errors. Four request bits each invert the next bit of their own class. A fifth request deletes the next start-of-frame bit position. That deletion slips the transmitted frame alignment by one bit and forces the far end to reframe.

A loopback select chooses between the framer stream and a loopback stream. Injection applies to whichever stream is selected. Output bits appear one clock after their input, with a valid flag. A deleted position shows as a cycle with the valid flag low.

Top module: `t1e1_err_inject`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid` is 0. Reset clears every armed request, so a qualifying bit sent after reset passes unchanged.
- R2: Writing 1 to a bit of `wr_data` while `wr_en` is high arms one error. Bit 0 arms a frame-alignment error, bit 1 a multiframe error, bit 2 a CRC error, bit 3 a test-pattern error and bit 4 a slot deletion.
- R3: Writing 0 to an inject bit leaves an armed request armed. Bits 7:5 of `wr_data` are reserved and have no effect on the output stream.
- R4: An armed frame error inverts the next valid bit tagged 1 (frame-alignment). Bits with other tags pass unchanged.
- R5: An armed multiframe error inverts the next valid bit tagged 2.
- R6: An armed CRC error inverts the next valid bit tagged 3.
- R7: An armed test-pattern error inverts the next valid bit tagged 4.
- R8: An armed deletion drops the next valid bit that has `sof` high. `out_valid` is low in the output cycle for that bit. A bit that is deleted does not consume any armed inversion.
- R9: Every valid bit that is not deleted appears on `out_bit` one clock later with `out_valid` high. Tags 0, 5, 6 and 7 are payload and are never altered. An input cycle with no valid bit gives `out_valid` low one clock later.
- R10: Each armed request produces exactly one error and then clears. Writing the same request again while it is still armed still produces only one error.
- R11: A write that arrives in the same cycle as a qualifying bit applies to the next qualifying bit, not to the current one.
- R12: Requests of different classes can be armed at the same time. Each one is serviced by its own class of bit, regardless of the order in which those bits arrive.
- R13: With `loop_en` high, the loopback stream (`lb_*`) is the source and the framer stream is ignored. Injection applies to the loopback stream in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Inject register write strobe |
| wr_data | input | 8 | Inject request bits (4:0) and reserved bits (7:5) |
| loop_en | input | 1 | Selects the loopback stream as source |
| tx_valid | input | 1 | Framer stream bit valid |
| tx_bit | input | 1 | Framer stream bit value |
| tx_tag | input | 3 | Framer stream bit class tag |
| tx_sof | input | 1 | Framer stream first bit position of frame |
| lb_valid | input | 1 | Loopback stream bit valid |
| lb_bit | input | 1 | Loopback stream bit value |
| lb_tag | input | 3 | Loopback stream bit class tag |
| lb_sof | input | 1 | Loopback stream first bit position of frame |
| out_valid | output | 1 | Output bit valid; low for a deleted position |
| out_bit | output | 1 | Output bit, possibly inverted |

## Verification
An armed flag that is stuck high shows up as repeated inversions on every later bit of that class. An armed flag that is lost or cleared early shows up as a missing inversion. Both appear on `out_bit` one clock after the first qualifying bit following the write.

A deletion that fires at the wrong moment shows up as a missing `out_valid` on the wrong cycle, also one clock later. A mis-routed field or tag compare errors a bit of the wrong class, which is visible at the first such bit. The vectors space writes and qualifying bits so that each of these faults changes a sampled output within a few cycles.

// File: rtl/tei_pkg.sv
package tei_pkg;

  localparam int TAG_W  = 3;
  localparam int REG_W  = 8;
  localparam int NINV   = 4;          // inverting request classes
  localparam int NCLS   = NINV + 1;   // plus slot deletion
  localparam int ALN_IX = NINV;       // deletion request bit position

  typedef enum logic [TAG_W-1:0] {
    TAG_PAY = 3'd0,
    TAG_FRM = 3'd1,
    TAG_MFR = 3'd2,
    TAG_CRC = 3'd3,
    TAG_PRB = 3'd4
  } bit_tag_e;

  // Tag that each inverting class (index into request bits) responds to.
  function automatic logic [TAG_W-1:0] class_tag(input int idx);
    case (idx)
      0:       class_tag = TAG_FRM;
      1:       class_tag = TAG_MFR;
      2:       class_tag = TAG_CRC;
      default: class_tag = TAG_PRB;
    endcase
  endfunction

  // Which inverting classes the current bit qualifies for.
  function automatic logic [NINV-1:0] inv_qualify(input logic vld,
                                                   input logic [TAG_W-1:0] tag);
    for (int i = 0; i < NINV; i++)
      inv_qualify[i] = vld && (tag == class_tag(i));
  endfunction

  // Next state of one armed flag.
  function automatic logic arm_next(input logic armed, input logic hit,
                                    input logic set);
    arm_next = (armed && !hit) || set;
  endfunction

endpackage

// File: rtl/tei_src_sel.sv
module tei_src_sel
  import tei_pkg::*;
(
  input  logic             loop_en,
  input  logic             tx_valid,
  input  logic             tx_bit,
  input  logic [TAG_W-1:0] tx_tag,
  input  logic             tx_sof,
  input  logic             lb_valid,
  input  logic             lb_bit,
  input  logic [TAG_W-1:0] lb_tag,
  input  logic             lb_sof,
  output logic             sel_valid,
  output logic             sel_bit,
  output logic [TAG_W-1:0] sel_tag,
  output logic             sel_sof
);

  always_comb begin
    if (loop_en) begin
      sel_valid = lb_valid;
      sel_bit   = lb_bit;
      sel_tag   = lb_tag;
      sel_sof   = lb_sof;
    end else begin
      sel_valid = tx_valid;
      sel_bit   = tx_bit;
      sel_tag   = tx_tag;
      sel_sof   = tx_sof;
    end
  end

endmodule

// File: rtl/tei_arm_cell.sv
module tei_arm_cell
  import tei_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic qual_i,
  input  logic block_i,
  output logic armed_o,
  output logic hit_o
);

  logic armed_q;

  assign hit_o   = armed_q && qual_i && !block_i;
  assign armed_o = armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= arm_next(armed_q, hit_o, set_i);
  end

endmodule

// File: rtl/tei_out_stage.sv
module tei_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_valid,
  input  logic sel_bit,
  input  logic drop,
  input  logic flip,
  output logic out_valid,
  output logic out_bit
);

  logic keep;
  assign keep = sel_valid && !drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= keep;
      out_bit   <= keep ? (sel_bit ^ flip) : 1'b0;
    end
  end

endmodule

// File: rtl/t1e1_err_inject.sv
module t1e1_err_inject
  import tei_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             loop_en,
  input  logic             tx_valid,
  input  logic             tx_bit,
  input  logic [TAG_W-1:0] tx_tag,
  input  logic             tx_sof,
  input  logic             lb_valid,
  input  logic             lb_bit,
  input  logic [TAG_W-1:0] lb_tag,
  input  logic             lb_sof,
  output logic             out_valid,
  output logic             out_bit
);

  // Selected source stream
  logic             sel_valid;
  logic             sel_bit;
  logic [TAG_W-1:0] sel_tag;
  logic             sel_sof;

  // Named internal events (observed by the checker)
  logic [NCLS-1:0]  wmask;
  logic [NINV-1:0]  inv_qual;
  logic [NINV-1:0]  inv_arm;
  logic [NINV-1:0]  inv_hit;
  logic             aln_arm;
  logic             aln_hit;
  logic             aln_qual;
  logic             any_flip;

  // Reserved bits (REG_W-1 : NCLS) are simply not used.
  assign wmask    = wr_en ? wr_data[NCLS-1:0] : '0;
  assign inv_qual = inv_qualify(sel_valid, sel_tag);
  assign aln_qual = sel_valid && sel_sof;
  assign any_flip = |inv_hit;

  tei_src_sel u_src (
    .loop_en  (loop_en),
    .tx_valid (tx_valid),
    .tx_bit   (tx_bit),
    .tx_tag   (tx_tag),
    .tx_sof   (tx_sof),
    .lb_valid (lb_valid),
    .lb_bit   (lb_bit),
    .lb_tag   (lb_tag),
    .lb_sof   (lb_sof),
    .sel_valid(sel_valid),
    .sel_bit  (sel_bit),
    .sel_tag  (sel_tag),
    .sel_sof  (sel_sof)
  );

  // Slot deletion request: never blocked.
  tei_arm_cell u_aln (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wmask[ALN_IX]),
    .qual_i (aln_qual),
    .block_i(1'b0),
    .armed_o(aln_arm),
    .hit_o  (aln_hit)
  );

  // Inverting requests: a deleted bit does not consume them.
  for (genvar i = 0; i < NINV; i++) begin : g_inv
    tei_arm_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (wmask[i]),
      .qual_i (inv_qual[i]),
      .block_i(aln_hit),
      .armed_o(inv_arm[i]),
      .hit_o  (inv_hit[i])
    );
  end

  tei_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_valid(sel_valid),
    .sel_bit  (sel_bit),
    .drop     (aln_hit),
    .flip     (any_flip),
    .out_valid(out_valid),
    .out_bit  (out_bit)
  );

endmodule

// File: rtl/tei_chk.sv
module tei_chk
  import tei_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NCLS-1:0] wmask,
  input logic            sel_valid,
  input logic            sel_bit,
  input logic [NCLS-1:0] arm,
  input logic [NCLS-1:0] hit,
  input logic            out_valid,
  input logic            out_bit
);

  AST_PASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !hit[ALN_IX]) |=> out_valid); // R9

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |=> !out_valid); // R9

  AST_DROP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    hit[ALN_IX] |=> !out_valid); // R8

  AST_FLIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_bit != $past(sel_bit))) |-> $past(|hit[NINV-1:0])); // R4

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & ~wmask)) |=> ((arm & $past(hit & ~wmask)) == '0)); // R10

  AST_HOLD_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (|(arm & ~hit)) |=> ((arm & $past(arm & ~hit)) == $past(arm & ~hit))); // R3

  AST_ARM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|wmask) |=> ((arm & $past(wmask)) == $past(wmask))); // R2

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit[NINV-1:0])); // R12

endmodule

bind t1e1_err_inject tei_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wmask    (wmask),
  .sel_valid(sel_valid),
  .sel_bit  (sel_bit),
  .arm      ({aln_arm, inv_arm}),
  .hit      ({aln_hit, inv_hit}),
  .out_valid(out_valid),
  .out_bit  (out_bit)
);

// File: tb/sim_t1e1_err_inject.sv
module sim_t1e1_err_inject;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic       we;
    logic [7:0] wd;
    logic       lp;
    logic       vl;
    logic       b;
    logic [2:0] tg;
    logic       sf;
    logic       ev;
    logic       eb;
    logic [3:0] rq;
  } vec_t;

  function automatic vec_t mk(input logic we, input logic [7:0] wd,
                              input logic lp, input logic vl, input logic b,
                              input logic [2:0] tg, input logic sf,
                              input logic ev, input logic eb,
                              input logic [3:0] rq);
    mk = '{we, wd, lp, vl, b, tg, sf, ev, eb, rq};
  endfunction

  localparam int NV = 39;
  // fields: we, wd, loop, valid, bit, tag, sof, exp_valid, exp_bit, req
  localparam vec_t VEC [NV] = '{
    mk(0, 8'h00, 0, 1, 1, 3'd1, 0, 1, 1, 4'd1),  // R1 nothing armed
    mk(1, 8'h01, 0, 1, 0, 3'd1, 0, 1, 0, 4'd11), // R11 same-cycle write
    mk(0, 8'h00, 0, 1, 1, 3'd0, 0, 1, 1, 4'd9),  // R9 payload
    mk(0, 8'h00, 0, 1, 0, 3'd2, 0, 1, 0, 4'd4),  // R4 other tag untouched
    mk(0, 8'h00, 0, 1, 0, 3'd1, 0, 1, 1, 4'd4),  // R4 frame inverted
    mk(0, 8'h00, 0, 1, 0, 3'd1, 0, 1, 0, 4'd10), // R10 single
    mk(1, 8'h02, 0, 0, 0, 3'd0, 0, 0, 0, 4'd9),  // R9 idle
    mk(0, 8'h00, 0, 1, 1, 3'd3, 0, 1, 1, 4'd5),  // R5 crc not touched
    mk(0, 8'h00, 0, 1, 1, 3'd2, 0, 1, 0, 4'd5),  // R5 multiframe inverted
    mk(1, 8'h04, 0, 1, 0, 3'd3, 0, 1, 0, 4'd11), // R11
    mk(0, 8'h00, 0, 1, 0, 3'd3, 0, 1, 1, 4'd6),  // R6 crc inverted
    mk(1, 8'h08, 0, 0, 0, 3'd0, 0, 0, 0, 4'd2),  // R2 arm prbs
    mk(1, 8'h00, 0, 0, 0, 3'd0, 0, 0, 0, 4'd3),  // R3 write zero
    mk(0, 8'h00, 0, 1, 1, 3'd4, 0, 1, 0, 4'd7),  // R7 prbs inverted
    mk(1, 8'hE0, 0, 0, 0, 3'd0, 0, 0, 0, 4'd3),  // R3 reserved only
    mk(0, 8'h00, 0, 1, 1, 3'd1, 0, 1, 1, 4'd3),
    mk(0, 8'h00, 0, 1, 1, 3'd2, 0, 1, 1, 4'd3),
    mk(0, 8'h00, 0, 1, 1, 3'd3, 0, 1, 1, 4'd3),
    mk(0, 8'h00, 0, 1, 1, 3'd4, 0, 1, 1, 4'd3),
    mk(0, 8'h00, 0, 1, 1, 3'd0, 1, 1, 1, 4'd3),
    mk(1, 8'h10, 0, 0, 0, 3'd0, 0, 0, 0, 4'd2),  // R2 arm deletion
    mk(0, 8'h00, 0, 1, 1, 3'd0, 0, 1, 1, 4'd8),  // R8 not sof
    mk(0, 8'h00, 0, 1, 1, 3'd1, 1, 0, 0, 4'd8),  // R8 deleted
    mk(0, 8'h00, 0, 1, 1, 3'd1, 1, 1, 1, 4'd10), // R10 single deletion
    mk(1, 8'h11, 0, 0, 0, 3'd0, 0, 0, 0, 4'd12), // R12 two requests
    mk(0, 8'h00, 0, 1, 0, 3'd1, 1, 0, 0, 4'd8),  // R8 deleted, frame kept
    mk(0, 8'h00, 0, 1, 0, 3'd1, 0, 1, 1, 4'd8),  // R8 frame applied later
    mk(1, 8'h0E, 0, 0, 0, 3'd0, 0, 0, 0, 4'd12),
    mk(0, 8'h00, 0, 1, 0, 3'd4, 0, 1, 1, 4'd12), // R12 prbs
    mk(0, 8'h00, 0, 1, 0, 3'd3, 0, 1, 1, 4'd12), // R12 crc
    mk(0, 8'h00, 0, 1, 0, 3'd2, 0, 1, 1, 4'd12), // R12 multiframe
    mk(1, 8'h01, 0, 0, 0, 3'd0, 0, 0, 0, 4'd10),
    mk(1, 8'h01, 0, 0, 0, 3'd0, 0, 0, 0, 4'd10), // R10 re-arm
    mk(0, 8'h00, 0, 1, 1, 3'd1, 0, 1, 0, 4'd10),
    mk(0, 8'h00, 0, 1, 1, 3'd1, 0, 1, 1, 4'd10), // R10 only one error
    mk(1, 8'h04, 1, 0, 0, 3'd0, 0, 0, 0, 4'd13), // R13 loopback
    mk(0, 8'h00, 1, 1, 1, 3'd3, 0, 1, 0, 4'd13), // R13 crc inverted
    mk(0, 8'h00, 1, 1, 0, 3'd0, 0, 1, 0, 4'd13),
    mk(0, 8'h00, 1, 1, 1, 3'd6, 0, 1, 1, 4'd9)   // R9 tag 6 is payload
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       loop_en = 1'b0;
  logic       tx_valid = 1'b0, tx_bit = 1'b0, tx_sof = 1'b0;
  logic [2:0] tx_tag = '0;
  logic       lb_valid = 1'b0, lb_bit = 1'b0, lb_sof = 1'b0;
  logic [2:0] lb_tag = '0;
  logic       out_valid, out_bit;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  t1e1_err_inject u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .loop_en(loop_en),
    .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_tag(tx_tag), .tx_sof(tx_sof),
    .lb_valid(lb_valid), .lb_bit(lb_bit), .lb_tag(lb_tag), .lb_sof(lb_sof),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Idle stream on the source that is not selected: opposite bit value.
  task automatic drive(input vec_t v);
    wr_en   = v.we;
    wr_data = v.wd;
    loop_en = v.lp;
    if (v.lp) begin
      {lb_valid, lb_bit, lb_tag, lb_sof} = {v.vl, v.b, v.tg, v.sf};
      {tx_valid, tx_bit, tx_tag, tx_sof} = {1'b1, ~v.b, 3'd1, 1'b1};
    end else begin
      {tx_valid, tx_bit, tx_tag, tx_sof} = {v.vl, v.b, v.tg, v.sf};
      {lb_valid, lb_bit, lb_tag, lb_sof} = {1'b1, ~v.b, 3'd1, 1'b1};
    end
  endtask

  initial begin
    #(CLK_P * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", out_valid, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    check("R1", "out_valid after reset", out_valid, 1'b0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k]);
      @(posedge clk); #2;
      check($sformatf("R%0d", VEC[k].rq), $sformatf("vec %0d valid", k),
            out_valid, VEC[k].ev);
      if (VEC[k].ev)
        check($sformatf("R%0d", VEC[k].rq), $sformatf("vec %0d bit", k),
              out_bit, VEC[k].eb);
    end

    // Directed R1: reset clears an armed request.
    @(negedge clk);
    drive(mk(1, 8'h1F, 0, 0, 0, 3'd0, 0, 0, 0, 4'd1));
    @(negedge clk);
    drive(mk(0, 8'h00, 0, 1, 1, 3'd0, 0, 0, 0, 4'd1));
    rst_n = 1'b0;
    @(posedge clk); #2;
    check("R1", "out_valid held in reset", out_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(mk(0, 8'h00, 0, 1, 1, 3'd1, 1, 0, 0, 4'd1));
    @(posedge clk); #2;
    check("R1", "frame bit after reset valid", out_valid, 1'b1);
    check("R1", "frame bit after reset value", out_bit, 1'b1);
    @(negedge clk);
    drive(mk(0, 8'h00, 0, 1, 0, 3'd4, 0, 0, 0, 4'd1));
    @(posedge clk); #2;
    check("R1", "prbs bit after reset value", out_bit, 1'b0);

    // Directed R11: armed request hit while re-written -> re-armed.
    @(negedge clk);
    drive(mk(1, 8'h08, 0, 0, 0, 3'd0, 0, 0, 0, 4'd11));
    @(negedge clk);
    drive(mk(1, 8'h08, 0, 1, 0, 3'd4, 0, 0, 0, 4'd11));
    @(posedge clk); #2;
    check("R11", "armed hit with rewrite", out_bit, 1'b1);
    @(negedge clk);
    drive(mk(0, 8'h00, 0, 1, 0, 3'd4, 0, 0, 0, 4'd11));
    @(posedge clk); #2;
    check("R11", "following prbs bit", out_bit, 1'b1);

    @(negedge clk);
    drive(mk(0, 8'h00, 0, 0, 0, 3'd0, 0, 0, 0, 4'd0));
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule